// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Block

This block is the software-visible register file for a two-channel bus-master disk DMA engine. A byte-addressed slave port reaches a 16-byte window: channel 0 sits at offsets 0–7 and channel 1 at offsets 8–15 (address bit 3 picks the channel). Each channel has a command byte, a status byte, a timing byte and a 32-bit descriptor-table base. One mode byte is shared by both channels and can be reached from either half of the window.

A command write turns into a one-cycle start or cancel pulse toward the DMA engine. The engine reports completion and errors back through per-channel event inputs. Each channel also drives an interrupt level into the block. The mode byte keeps those two levels as pending bits, next to a block bit for each channel, and reduces them to one interrupt output. The parameter `HAS_MODE` removes the mode byte and the timing bytes for a plainer variant.

Top module: `bm_dma_regs`

## Requirements
- R1: While `rst_n` is low, every register reads zero, `irq_out` is low and `cancel_pls` is 2'b11. At the first clock edge after release, `cancel_pls` returns to 0 unless a command write asks for a cancel.
- R2: Offset layout within a channel: 0 is command, 1 is mode, 2 is status, 3 is timing, 4–7 is the base. `acc_size` is 0 for byte, 1 for halfword, 2 or 3 for word. At offsets 0–3 only byte accesses act: wider writes are ignored and wider reads return 0.
- R3: A command write keeps only data bits 0 (start) and 3 (direction). Every other command bit reads 0.
- R4: A command write with bit 0 clear raises that channel's `cancel_pls` for exactly one cycle, starting after the write edge, and clears status bit 0 (active).
- R5: A command write with bit 0 set, while status bit 0 is clear, sets status bit 0 and raises `start_pls` for one cycle. If the channel is already active, no pulse is issued.
- R6: A status write loads bits 6:5 from the data and keeps bit 0. Bits 2:1 are cleared where the data has a 1 and are kept otherwise. Bits 7, 4 and 3 read 0.
- R7: A base write of byte or halfword size merges the data at a shift of (offset mod 4)×8 bits, and bits beyond bit 31 are dropped. A word write replaces the whole register, whatever the offset. Bits 1:0 are always stored as 0, and the base drives `tbl_base0`/`tbl_base1`.
- R8: A base read returns the whole register for a word access. For a byte or halfword access it returns the register shifted right by (offset mod 4)×8 and masked to 8 or 16 bits.
- R9: The mode byte holds channel 0 pending in bit 2 and channel 1 pending in bit 3. Bits 4 and 5 block channel 0 and channel 1. The pending bits follow `chan_irq` one cycle later. A write changes only bits 4 and 5, and the same byte appears at offsets 1 and 9.
- R10: `irq_out` is high when bit 2 is set and bit 4 is clear, or when bit 3 is set and bit 5 is clear.
- R11: With `HAS_MODE`=0, offsets 1 and 3 read 0xFF and ignore writes, and `irq_out` is the OR of the registered pending levels.
- R12: `eng_done[n]` or `eng_err[n]` clears active and sets bit 2 or bit 1 respectively. These events override a status or command write to the same bits in the same cycle.
- R13: Each channel has its own 8-bit timing byte at offset 3, which can be read and written freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 4 | Byte offset in the window |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| acc_wdata | input | 32 | Write data, right-justified |
| acc_rdata | output | 32 | Read data for the current address and size |
| chan_irq | input | 2 | Per-channel interrupt levels |
| eng_done | input | 2 | Per-channel transfer-complete event |
| eng_err | input | 2 | Per-channel error event |
| start_pls | output | 2 | Per-channel start pulse |
| cancel_pls | output | 2 | Per-channel cancel pulse |
| irq_out | output | 1 | Merged interrupt level |
| tbl_base0 | output | 32 | Channel 0 descriptor-table base |
| tbl_base1 | output | 32 | Channel 1 descriptor-table base |

## Verification
The bench builds two copies that share the same stimulus: one with `HAS_MODE`=1 and one with `HAS_MODE`=0. This lets the same writes to offsets 1 and 3 show blocking and timing storage in one copy, and the constant 0xFF reads and unblocked interrupt in the other. Directed sequences cover the status-bit mixes, repeated starts, and engine events that collide with bus writes. After those, a long pseudo-random run reaches unaligned halfword writes near the top of the base register and wide accesses to the byte-only offsets.

// File: rtl/bm_dma_regs.sv
module bm_dma_regs #(
  parameter bit HAS_MODE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_wr,
  input  logic [3:0]  acc_addr,
  input  logic [1:0]  acc_size,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  input  logic [1:0]  chan_irq,
  input  logic [1:0]  eng_done,
  input  logic [1:0]  eng_err,
  output logic [1:0]  start_pls,
  output logic [1:0]  cancel_pls,
  output logic        irq_out,
  output logic [31:0] tbl_base0,
  output logic [31:0] tbl_base1
);

  logic [7:0]  cmd_q  [2];
  logic [7:0]  st_q   [2];
  logic [7:0]  tim_q  [2];
  logic [31:0] base_q [2];
  logic [7:0]  st_nx  [2];
  logic [31:0] base_nx[2];
  logic [1:0]  pend_q, blk_q, hit, go, stop;

  wire        is_byte = (acc_size == 2'd0);
  wire        rc      = acc_addr[3];
  wire [4:0]  sh      = {acc_addr[1:0], 3'b000};
  wire [31:0] wmask   = acc_size[1] ? 32'hFFFF_FFFF
                                    : ((acc_size[0] ? 32'h0000_FFFF : 32'h0000_00FF) << sh);
  wire [31:0] wval    = acc_size[1] ? acc_wdata : (acc_wdata << sh);
  wire        reg_wr  = acc_en & acc_wr & is_byte & ~acc_addr[2];
  wire [7:0]  mode_b  = {2'b00, blk_q, pend_q, 2'b00};

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      hit[i]     = acc_en & acc_wr & (acc_addr[3] == 1'(i));
      go[i]      = 1'b0;
      stop[i]    = 1'b0;
      st_nx[i]   = st_q[i];
      base_nx[i] = ((base_q[i] & ~wmask) | (wval & wmask)) & ~32'h3;
      if (hit[i] && reg_wr && acc_addr[1:0] == 2'd2)
        st_nx[i] = {1'b0, acc_wdata[6:5], 2'b00, st_q[i][2:1] & ~acc_wdata[2:1], st_q[i][0]};
      if (hit[i] && reg_wr && acc_addr[1:0] == 2'd0) begin
        if (acc_wdata[0]) begin
          if (!st_q[i][0]) begin
            go[i]       = 1'b1;
            st_nx[i][0] = 1'b1;
          end
        end else begin
          stop[i]     = 1'b1;
          st_nx[i][0] = 1'b0;
        end
      end
      if (eng_done[i] | eng_err[i]) begin
        st_nx[i][0] = 1'b0;
        st_nx[i][1] = st_nx[i][1] | eng_err[i];
        st_nx[i][2] = st_nx[i][2] | eng_done[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        cmd_q[i]  <= '0;
        st_q[i]   <= '0;
        tim_q[i]  <= '0;
        base_q[i] <= '0;
      end
      pend_q     <= '0;
      blk_q      <= '0;
      start_pls  <= '0;
      cancel_pls <= 2'b11;
    end else begin
      pend_q     <= chan_irq;
      start_pls  <= go;
      cancel_pls <= stop;
      if (HAS_MODE && acc_en && acc_wr && is_byte && acc_addr[2:0] == 3'd1)
        blk_q <= acc_wdata[5:4];
      for (int i = 0; i < 2; i++) begin
        st_q[i] <= st_nx[i];
        if (hit[i] && reg_wr && acc_addr[1:0] == 2'd0) cmd_q[i] <= acc_wdata[7:0] & 8'h09;
        if (HAS_MODE && hit[i] && reg_wr && acc_addr[1:0] == 2'd3) tim_q[i] <= acc_wdata[7:0];
        if (hit[i] && acc_addr[2]) base_q[i] <= base_nx[i];
      end
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (!acc_addr[2]) begin
      if (is_byte)
        case (acc_addr[1:0])
          2'd0:    acc_rdata = {24'h0, cmd_q[rc]};
          2'd1:    acc_rdata = HAS_MODE ? {24'h0, mode_b} : 32'hFF;
          2'd2:    acc_rdata = {24'h0, st_q[rc]};
          default: acc_rdata = HAS_MODE ? {24'h0, tim_q[rc]} : 32'hFF;
        endcase
    end else if (acc_size[1]) begin
      acc_rdata = base_q[rc];
    end else begin
      acc_rdata = (base_q[rc] >> sh) & (acc_size[0] ? 32'h0000_FFFF : 32'h0000_00FF);
    end
  end

  assign irq_out   = |(pend_q & ~blk_q);
  assign tbl_base0 = base_q[0];
  assign tbl_base1 = base_q[1];

  p_start_from_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_pls[0] |-> $past(st_q[0][0]) == 1'b0);
  p_err_sets_bit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err[1] |=> st_q[1][1] && !st_q[1][0]);
  p_done_sets_bit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done[0] |=> st_q[0][2] && !st_q[0][0]);
  p_irq_needs_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> pend_q != 2'b00);
  p_cancel_idles_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_pls[1] |-> !st_q[1][0]);
  p_base_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_base0[1:0] == 2'b00 && tbl_base1[1:0] == 2'b00);

endmodule

// File: tb/tb_bm_dma_regs.sv
module tb_bm_dma_regs;
  logic clk = 0, rst_n = 0;
  logic acc_en = 0, acc_wr = 0;
  logic [3:0] acc_addr = 0;
  logic [1:0] acc_size = 0;
  logic [31:0] acc_wdata = 0;
  logic [1:0] chan_irq = 0, eng_done = 0, eng_err = 0;
  logic [31:0] rd_f, rd_l, b0_f, b1_f, b0_l, b1_l;
  logic [1:0] sp_f, cp_f, sp_l, cp_l;
  logic irq_f, irq_l;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bm_dma_regs #(.HAS_MODE(1'b1)) dut (.clk, .rst_n, .acc_en, .acc_wr, .acc_addr, .acc_size,
    .acc_wdata, .acc_rdata(rd_f), .chan_irq, .eng_done, .eng_err, .start_pls(sp_f),
    .cancel_pls(cp_f), .irq_out(irq_f), .tbl_base0(b0_f), .tbl_base1(b1_f));
  bm_dma_regs #(.HAS_MODE(1'b0)) dut_lite (.clk, .rst_n, .acc_en, .acc_wr, .acc_addr, .acc_size,
    .acc_wdata, .acc_rdata(rd_l), .chan_irq, .eng_done, .eng_err, .start_pls(sp_l),
    .cancel_pls(cp_l), .irq_out(irq_l), .tbl_base0(b0_l), .tbl_base1(b1_l));

  // reference model
  int m_cmd[2], m_st[2], m_tim[2];
  logic [31:0] m_base[2];
  int m_pend, m_blk, m_start, m_cancel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin m_cmd[i] = 0; m_st[i] = 0; m_tim[i] = 0; m_base[i] = 0; end
      m_pend = 0; m_blk = 0; m_start = 0; m_cancel = 3;
    end else begin
      int c, off, w;
      logic [31:0] mask, sh;
      c = acc_addr[3]; off = acc_addr[2:0]; w = acc_wdata;
      m_start = 0; m_cancel = 0;
      if (acc_en && acc_wr) begin
        if (off >= 4) begin
          if (acc_size >= 2) m_base[c] = acc_wdata & ~32'h3;
          else begin
            sh = (off % 4) * 8;
            mask = (acc_size == 1) ? 32'hFFFF : 32'hFF;
            m_base[c] = ((m_base[c] & ~(mask << sh)) | ((acc_wdata & mask) << sh)) & ~32'h3;
          end
        end else if (acc_size == 0) begin
          if (off == 0) begin
            m_cmd[c] = w & 9;
            if (w & 1) begin
              if ((m_st[c] & 1) == 0) begin m_st[c] |= 1; m_start |= (1 << c); end
            end else begin
              m_cancel |= (1 << c); m_st[c] &= ~1;
            end
          end
          if (off == 1) m_blk = (w >> 4) & 3;
          if (off == 2) m_st[c] = (w & 'h60) | (m_st[c] & 1) | (m_st[c] & ~w & 6);
          if (off == 3) m_tim[c] = w & 'hFF;
        end
      end
      for (int i = 0; i < 2; i++)
        if (eng_done[i] || eng_err[i]) begin
          m_st[i] &= ~1;
          if (eng_err[i]) m_st[i] |= 2;
          if (eng_done[i]) m_st[i] |= 4;
        end
      m_pend = chan_irq;
    end
  end

  function automatic logic [31:0] mread(bit lite);
    int c, off, sh;
    c = acc_addr[3]; off = acc_addr[2:0]; sh = (off % 4) * 8;
    if (off >= 4) begin
      if (acc_size >= 2) return m_base[c];
      return (m_base[c] >> sh) & ((acc_size == 1) ? 32'hFFFF : 32'hFF);
    end
    if (acc_size != 0) return 0;
    case (off)
      0: return m_cmd[c];
      1: return lite ? 32'hFF : ((m_blk << 4) | (m_pend << 2));
      2: return m_st[c];
      default: return lite ? 32'hFF : m_tim[c];
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    string t;
    if (acc_addr[2]) t = "R8 base read";
    else if (acc_size != 0) t = "R2 wide access";
    else case (acc_addr[1:0])
      0: t = "R3 command"; 1: t = "R9 mode"; 2: t = "R6 status"; default: t = "R13 timing";
    endcase
    chk(t, rd_f, mread(0));
    chk("R11 lite read", rd_l, mread(1));
    chk("R5 start_pls", 32'(sp_f), 32'(m_start));
    chk("R4 cancel_pls", 32'(cp_f), 32'(m_cancel));
    chk("R10 irq_out", 32'(irq_f), 32'((m_pend & ~m_blk) != 0));
    chk("R11 lite irq_out", 32'(irq_l), 32'(m_pend != 0));
    chk("R7 tbl_base0", b0_f, m_base[0]);
    chk("R7 tbl_base1", b1_f, m_base[1]);
    chk("R12 lite start", 32'(sp_l), 32'(m_start));
  endtask

  task automatic step(bit en, bit wr, int addr, int size, logic [31:0] wd,
                      logic [1:0] dn = 0, logic [1:0] er = 0);
    @(negedge clk);
    compare();
    acc_en = en; acc_wr = wr; acc_addr = 4'(addr); acc_size = 2'(size);
    acc_wdata = wd; eng_done = dn; eng_err = er;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset cancel", 32'(cp_f), 32'h3);
    chk("R1 reset irq", 32'(irq_f), 0);
    chk("R1 reset base", b0_f, 0);
    chk("R1 reset status", rd_f, 0);
    rst_n = 1;
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);                  // R1 cancel drops
    step(1, 1, 0, 0, 32'hFF);             // R3/R5 start ch0
    step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 32'h01);             // R5 no repeat start
    step(1, 0, 2, 0, 0);
    step(1, 1, 8, 0, 32'h09);             // ch1 start
    step(1, 1, 2, 0, 0, 2'b01, 2'b10);    // R12 override with status write
    step(1, 0, 10, 0, 0);
    step(1, 1, 2, 0, 32'hFF);             // R6 clear bits
    step(1, 0, 2, 0, 0);
    step(1, 1, 10, 0, 32'h62);            // R6 partial clear
    step(1, 0, 10, 0, 0);
    step(1, 1, 8, 0, 32'h00);             // R4 cancel
    step(1, 1, 0, 0, 32'h01, 2'b01, 0);   // R12 vs start same cycle
    step(1, 1, 4, 2, 32'hDEADBEEF);       // R7 word
    step(1, 1, 5, 0, 32'h77);             // byte
    step(1, 1, 7, 1, 32'hABCD);           // halfword top truncation
    step(1, 0, 6, 1, 0);
    step(1, 1, 14, 2, 32'h1234_5677);     // R7 word at offset mod 4 = 2
    step(1, 0, 13, 0, 0);
    step(1, 1, 12, 0, 32'h03);            // low bits forced zero
    step(1, 0, 15, 1, 0);
    step(1, 1, 0, 2, 32'h1);              // R2 wide write ignored
    step(1, 0, 0, 1, 0);
    step(1, 1, 3, 0, 32'h5A);             // R13 timing ch0
    step(1, 1, 11, 0, 32'hA5);            // R13 timing ch1
    step(1, 0, 3, 0, 0);
    step(1, 0, 11, 0, 0);
    chan_irq = 2'b01;
    step(1, 0, 1, 0, 0);                  // R9 pending
    step(1, 1, 9, 0, 32'hFF);             // R9 write via ch1 window blocks both
    step(1, 0, 1, 0, 0);
    chan_irq = 2'b11;
    step(1, 1, 1, 0, 32'h20);             // R10 unblock ch0
    step(1, 0, 9, 0, 0);
    chan_irq = 2'b10;
    step(1, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 9) == 0) chan_irq = 2'($urandom);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 15),
           $urandom_range(0, 3), $urandom,
           ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00,
           ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00);
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule